// File: doc/BRIEF.md
# Vectored Interrupt Message Aggregator

This block collects a set of raw interrupt lines (64 by default) and turns them into a stream of vector-tagged messages. Software configures each line through a 32-bit register port. Each line has the following settings:

- a trigger mode: edge or level;
- a polarity: active high/rising or active low/falling;
- a blocking bit;
- a message-enable bit;
- an 8-bit vector;
- an 8-bit route.

Edge events are held in sticky latches. Software clears these latches by writing ones to a clear word.

On the output side the block presents one message at a time. A message carries the vector, route and index of the lowest-numbered line that is pending, unblocked, enabled and not yet delivered. The message is held under a valid/ready handshake. An edge line is delivered once per latched event. A still-asserted level line is delivered again only after it goes inactive, or after it has been blocked and then unblocked.

The register port decodes reads combinationally: read data reflects the current address. A write takes effect at the clock edge where the write enable is high. The raw interrupt inputs are synchronised with two flops before any use.

Top module: `irq_vector_hub`

## Requirements
- R1: After reset every blocking bit is 1 (both block words read 0xFFFFFFFF), every other word and byte register reads 0, all edge latches are clear, and msgValid is 0.
- R2: Word registers sit at these byte offsets: block 0x20, message enable 0x40, edge select 0x60, clear 0x80, polarity 0x3E0, spare words 0xC0 and 0xE0. Word k of each register is at offset+4k. Line n is bit n%32 of word n/32. Every word except the clear word reads back exactly what was last written. The clear word reads 0.
- R3: Line n has a route byte at 0x100+n and a vector byte at 0x200+n. A write stores bits 7:0 of the write data. A read returns the byte in bits 7:0 and zeros above.
- R4: The trigger is set by the pair (edge, polarity): (1,0) is rising edge, (1,1) is falling edge, (0,0) is active-high level, (0,1) is active-low level.
- R5: A level line is pending while its synchronised input, XOR its polarity bit, is 1.
- R6: An edge line becomes pending on a synchronised transition in its selected direction. It stays pending until cleared, whatever the input does afterwards.
- R7: Writing 1 to a clear-word bit clears that line's edge latch. Writing 0 leaves the latch untouched.
- R8: A line produces a message only while its blocking bit is 0 and its message-enable bit is 1.
- R9: Among eligible lines, the lowest-numbered one is issued first. msgVector, msgRoute and msgSrc carry that line's vector byte, route byte and index.
- R10: While msgValid is 1 and msgReady is 0, msgValid and the message fields stay unchanged.
- R11: An edge line that has been issued is not issued again until its latch is cleared and then set by a new edge.
- R12: An issued level line that stays asserted is issued again only after it has been inactive, or has been blocked and then unblocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| irqIn | input | NUM_SRC | Raw interrupt lines |
| msgValid | output | 1 | A message is presented |
| msgReady | input | 1 | Downstream accepts the message |
| msgVector | output | 8 | Vector byte of the presented line |
| msgRoute | output | 8 | Route byte of the presented line |
| msgSrc | output | log2(NUM_SRC) | Index of the presented line |

## Verification
The hardest cases to reach from the ports are three. The first is a true arbitration race, where several lines become eligible in the same cycle. The bench gets there by unblocking the lines first and then raising their inputs with a single assignment, so the synchroniser delivers them together. The second is proving that a zero write to the clear word leaves a latch alone, since a latched line that has already been issued is invisible at the output. The bench gets there by latching an edge with message enable off, writing zeros, and then enabling: the message that appears is the evidence. The third is proving that a one write does clear a latch. The bench shows this by repeating the sequence with a one write and seeing no message. A full sweep over every line checks the vector and route lookup for each index.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int BYTE_W     = 8;
  localparam int OFF_MASK   = 'h020;
  localparam int OFF_MSGEN  = 'h040;
  localparam int OFF_EDGE   = 'h060;
  localparam int OFF_CLR    = 'h080;
  localparam int OFF_SPARE0 = 'h0C0;
  localparam int OFF_SPARE1 = 'h0E0;
  localparam int OFF_ROUTE  = 'h100;
  localparam int OFF_VEC    = 'h200;
  localparam int OFF_POL    = 'h3E0;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_MASK, SEL_MSGEN, SEL_EDGE, SEL_CLR,
    SEL_POL, SEL_SPARE0, SEL_SPARE1, SEL_ROUTE, SEL_VEC
  } reg_sel_e;

  typedef struct packed {
    logic       wrStb;
    reg_sel_e   sel;
    logic [7:0] idx;
    logic       issueStb;
  } hub_cmd_t;
endpackage

// File: rtl/irq_hub_ctrl.sv
module irq_hub_ctrl
  import irq_hub_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [11:0] regAddr,
  input  logic        hasWin,
  input  logic        msgReady,
  output hub_cmd_t    cmd,
  output logic        msgValid
);
  localparam int NWORDS = NUM_SRC / 32;
  localparam int SPAN   = 4 * NWORDS;

  function automatic logic inWin(input int a, input int base);
    return (a >= base) && (a < base + SPAN) && (a % 4 == 0);
  endfunction

  int         addrI;
  reg_sel_e   selD;
  logic [7:0] idxD;
  logic       issue;

  always_comb begin
    addrI = int'(regAddr);
    selD  = SEL_NONE;
    idxD  = '0;
    if (addrI >= OFF_ROUTE && addrI < OFF_ROUTE + NUM_SRC) begin
      selD = SEL_ROUTE; idxD = 8'(addrI - OFF_ROUTE);
    end else if (addrI >= OFF_VEC && addrI < OFF_VEC + NUM_SRC) begin
      selD = SEL_VEC; idxD = 8'(addrI - OFF_VEC);
    end else if (inWin(addrI, OFF_MASK)) begin
      selD = SEL_MASK; idxD = 8'((addrI - OFF_MASK) / 4);
    end else if (inWin(addrI, OFF_MSGEN)) begin
      selD = SEL_MSGEN; idxD = 8'((addrI - OFF_MSGEN) / 4);
    end else if (inWin(addrI, OFF_EDGE)) begin
      selD = SEL_EDGE; idxD = 8'((addrI - OFF_EDGE) / 4);
    end else if (inWin(addrI, OFF_CLR)) begin
      selD = SEL_CLR; idxD = 8'((addrI - OFF_CLR) / 4);
    end else if (inWin(addrI, OFF_SPARE0)) begin
      selD = SEL_SPARE0; idxD = 8'((addrI - OFF_SPARE0) / 4);
    end else if (inWin(addrI, OFF_SPARE1)) begin
      selD = SEL_SPARE1; idxD = 8'((addrI - OFF_SPARE1) / 4);
    end else if (inWin(addrI, OFF_POL)) begin
      selD = SEL_POL; idxD = 8'((addrI - OFF_POL) / 4);
    end
  end

  // A new message loads when a winner exists and the output slot is free or draining.
  assign issue = hasWin && (!msgValid || msgReady);

  always_ff @(posedge clk) begin
    if (!rstN)         msgValid <= 1'b0;
    else if (issue)    msgValid <= 1'b1;
    else if (msgReady) msgValid <= 1'b0;
  end

  assign cmd = '{wrStb: regWrEn && (selD != SEL_NONE), sel: selD, idx: idxD, issueStb: issue};
endmodule

// File: rtl/irq_hub_dp.sv
module irq_hub_dp
  import irq_hub_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  hub_cmd_t           cmd,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  input  logic [NUM_SRC-1:0] irqIn,
  output logic               hasWin,
  output logic [IDX_W-1:0]   winIdx,
  output logic [BYTE_W-1:0]  msgVector,
  output logic [BYTE_W-1:0]  msgRoute,
  output logic [IDX_W-1:0]   msgSrc
);
  localparam int NWORDS = NUM_SRC / 32;

  logic [NUM_SRC-1:0] maskQ, enQ, edgeQ, polQ, spare0Q, spare1Q;
  logic [NUM_SRC-1:0] s1Q, s2Q, prevQ, latchQ, sentQ;
  logic [NUM_SRC-1:0] clrVec, evt, pend, elig, sentKeep;
  logic [BYTE_W-1:0]  routeMem [NUM_SRC];
  logic [BYTE_W-1:0]  vecMem   [NUM_SRC];
  logic [IDX_W-1:0]   byteIdx;

  assign byteIdx = cmd.idx[IDX_W-1:0];

  // Word-wide configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ <= '1; enQ <= '0; edgeQ <= '0; polQ <= '0; spare0Q <= '0; spare1Q <= '0;
    end else if (cmd.wrStb) begin
      for (int w = 0; w < NWORDS; w++) begin
        if (cmd.idx == 8'(w)) begin
          case (cmd.sel)
            SEL_MASK:   maskQ[w*32 +: 32]   <= wrData;
            SEL_MSGEN:  enQ[w*32 +: 32]     <= wrData;
            SEL_EDGE:   edgeQ[w*32 +: 32]   <= wrData;
            SEL_POL:    polQ[w*32 +: 32]    <= wrData;
            SEL_SPARE0: spare0Q[w*32 +: 32] <= wrData;
            SEL_SPARE1: spare1Q[w*32 +: 32] <= wrData;
            default: ;
          endcase
        end
      end
    end
  end

  // Per-line route and vector bytes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        routeMem[i] <= '0;
        vecMem[i]   <= '0;
      end
    end else if (cmd.wrStb && cmd.sel == SEL_ROUTE) begin
      routeMem[byteIdx] <= wrData[BYTE_W-1:0];
    end else if (cmd.wrStb && cmd.sel == SEL_VEC) begin
      vecMem[byteIdx] <= wrData[BYTE_W-1:0];
    end
  end

  // Read mux
  always_comb begin
    rdData = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (cmd.idx == 8'(w)) begin
        case (cmd.sel)
          SEL_MASK:   rdData = maskQ[w*32 +: 32];
          SEL_MSGEN:  rdData = enQ[w*32 +: 32];
          SEL_EDGE:   rdData = edgeQ[w*32 +: 32];
          SEL_POL:    rdData = polQ[w*32 +: 32];
          SEL_SPARE0: rdData = spare0Q[w*32 +: 32];
          SEL_SPARE1: rdData = spare1Q[w*32 +: 32];
          default: ;
        endcase
      end
    end
    if (cmd.sel == SEL_ROUTE) rdData = {24'h0, routeMem[byteIdx]};
    if (cmd.sel == SEL_VEC)   rdData = {24'h0, vecMem[byteIdx]};
  end

  // Clear-word ones, expanded per word
  for (genvar w = 0; w < NWORDS; w++) begin : g_clr
    assign clrVec[w*32 +: 32] =
      (cmd.wrStb && cmd.sel == SEL_CLR && cmd.idx == 8'(w)) ? wrData : 32'h0;
  end

  // Per-line trigger evaluation
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign evt[i]      = edgeQ[i] && (polQ[i] ? (prevQ[i] && !s2Q[i]) : (!prevQ[i] && s2Q[i]));
    assign pend[i]     = edgeQ[i] ? latchQ[i] : (s2Q[i] ^ polQ[i]);
    assign elig[i]     = pend[i] && !maskQ[i] && enQ[i] && !sentQ[i];
    assign sentKeep[i] = sentQ[i] && pend[i] && !(maskQ[i] && !edgeQ[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Q <= '0; s2Q <= '0; prevQ <= '0; latchQ <= '0;
    end else begin
      s1Q    <= irqIn;
      s2Q    <= s1Q;
      prevQ  <= s2Q;
      latchQ <= (latchQ & ~clrVec) | evt;
    end
  end

  // Lowest-index winner
  always_comb begin
    hasWin = |elig;
    winIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig[i]) winIdx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sentQ <= '0; msgVector <= '0; msgRoute <= '0; msgSrc <= '0;
    end else begin
      sentQ <= sentKeep | (cmd.issueStb ? (NUM_SRC'(1) << winIdx) : '0);
      if (cmd.issueStb) begin
        msgVector <= vecMem[winIdx];
        msgRoute  <= routeMem[winIdx];
        msgSrc    <= winIdx;
      end
    end
  end
endmodule

// File: rtl/irq_vector_hub.sv
module irq_vector_hub
  import irq_hub_pkg::*;
#(
  parameter int NUM_SRC = 64,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [11:0]        regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  input  logic [NUM_SRC-1:0] irqIn,
  output logic               msgValid,
  input  logic               msgReady,
  output logic [7:0]         msgVector,
  output logic [7:0]         msgRoute,
  output logic [IDX_W-1:0]   msgSrc
);
  hub_cmd_t         cmd;
  logic             hasWin;
  logic [IDX_W-1:0] winIdx;

  irq_hub_ctrl #(.NUM_SRC(NUM_SRC)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .hasWin(hasWin), .msgReady(msgReady), .cmd(cmd), .msgValid(msgValid)
  );

  irq_hub_dp #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrData(regWrData), .rdData(regRdData),
    .irqIn(irqIn), .hasWin(hasWin), .winIdx(winIdx),
    .msgVector(msgVector), .msgRoute(msgRoute), .msgSrc(msgSrc)
  );
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter int NUM_SRC = 64
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       msgValid,
  input logic                       msgReady,
  input logic [7:0]                 msgVector,
  input logic [7:0]                 msgRoute,
  input logic [$clog2(NUM_SRC)-1:0] msgSrc,
  input logic                       hasWin
);
  // R10: a stalled message holds every field
  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && !msgReady |=> msgValid && $stable(msgVector) && $stable(msgRoute) && $stable(msgSrc));

  // R9: a message only appears when the arbiter had a winner
  p_new_has_win_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(msgValid) |-> $past(hasWin));

  // R11 / R12: an accepted line is never presented again on the very next cycle
  p_no_repeat_r11: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && msgReady |=> !(msgValid && msgSrc == $past(msgSrc)));

  // R1: leaving reset with no message presented
  p_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !msgValid);
endmodule

bind irq_vector_hub irq_hub_chk #(.NUM_SRC(NUM_SRC)) chk_i (
  .clk(clk), .rstN(rstN), .msgValid(msgValid), .msgReady(msgReady),
  .msgVector(msgVector), .msgRoute(msgRoute), .msgSrc(msgSrc), .hasWin(hasWin)
);

// File: tb/irq_vector_hub_tb.sv
module irq_vector_hub_tb_top;
  localparam int NS = 64;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic [11:0]   regAddr = '0;
  logic [31:0]   regWrData = '0;
  logic [31:0]   regRdData;
  logic [NS-1:0] irqIn = '0;
  logic          msgReady = 1'b0;
  logic          msgValid;
  logic [7:0]    msgVector, msgRoute;
  logic [5:0]    msgSrc;

  int  nRun = 0, nFail = 0;
  bit  done = 1'b0;
  logic [31:0] maskSh [2];
  logic [31:0] enSh   [2];
  logic [31:0] edgeSh [2];
  logic [31:0] polSh  [2];

  always #10 clk = ~clk;

  irq_vector_hub #(.NUM_SRC(NS)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqIn(irqIn), .msgValid(msgValid), .msgReady(msgReady),
    .msgVector(msgVector), .msgRoute(msgRoute), .msgSrc(msgSrc)
  );

  function automatic logic [7:0] vecOf(input int n);
    return 8'(n * 3 + 17);
  endfunction
  function automatic logic [7:0] routeOf(input int n);
    return 8'(n) ^ 8'h5A;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  // which: 0 block, 1 enable, 2 edge, 3 polarity
  task automatic setCfg(input int which, input int n, input logic v);
    int w;
    w = n / 32;
    case (which)
      0: begin maskSh[w][n%32] = v; wr(12'(32'h20  + 4*w), maskSh[w]); end
      1: begin enSh[w][n%32]   = v; wr(12'(32'h40  + 4*w), enSh[w]);   end
      2: begin edgeSh[w][n%32] = v; wr(12'(32'h60  + 4*w), edgeSh[w]); end
      default: begin polSh[w][n%32] = v; wr(12'(32'h3E0 + 4*w), polSh[w]); end
    endcase
  endtask

  task automatic clrLatch(input int n);
    wr(12'(32'h80 + 4*(n/32)), 32'h1 << (n % 32));
  endtask

  task automatic accept();
    @(negedge clk); msgReady = 1'b1;
    @(negedge clk); msgReady = 1'b0;
  endtask

  task automatic expMsg(input string tag, input int n);
    chk({tag, " valid"},  {31'h0, msgValid}, 32'h1);
    chk({tag, " src"},    {26'h0, msgSrc},   32'(n));
    chk({tag, " vector"}, {24'h0, msgVector}, {24'h0, vecOf(n)});
    chk({tag, " route"},  {24'h0, msgRoute},  {24'h0, routeOf(n)});
  endtask

  task automatic expNone(input string tag);
    chk({tag, " no message"}, {31'h0, msgValid}, 32'h0);
  endtask

  task automatic pulse(input int n);
    irqIn[n] = 1'b1; idle(3);
    irqIn[n] = 1'b0; idle(6);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [11:0] offs [6];
    offs[0] = 12'h20;  offs[1] = 12'h40;  offs[2] = 12'h60;
    offs[3] = 12'h3E0; offs[4] = 12'hC0;  offs[5] = 12'hE0;
    for (int w = 0; w < 2; w++) begin
      maskSh[w] = '1; enSh[w] = '0; edgeSh[w] = '0; polSh[w] = '0;
    end

    idle(3);
    rstN = 1'b1;
    idle(2);

    // R1: reset values
    for (int r = 0; r < 6; r++)
      for (int w = 0; w < 2; w++) begin
        rd(offs[r] + 12'(4*w), d);
        chk("R1 reset word", d, (r == 0) ? 32'hFFFF_FFFF : 32'h0);
      end
    rd(12'h100, d); chk("R1 reset route", d, 32'h0);
    rd(12'h23F, d); chk("R1 reset vector", d, 32'h0);
    expNone("R1 reset");

    // R2: word readback sweep, each restored before the next
    for (int r = 0; r < 6; r++)
      for (int w = 0; w < 2; w++) begin
        logic [31:0] pat;
        pat = 32'h9E37_79B9 * 32'(r * 2 + w + 1);
        wr(offs[r] + 12'(4*w), pat);
        rd(offs[r] + 12'(4*w), d);
        chk("R2 word readback", d, pat);
        wr(offs[r] + 12'(4*w), (r == 0) ? 32'hFFFF_FFFF : 32'h0);
      end
    wr(12'h84, 32'hFFFF_FFFF);
    rd(12'h84, d); chk("R2 clear word reads zero", d, 32'h0);
    expNone("R2 sweep side effect");

    // R3: byte registers, upper write bits discarded
    for (int n = 0; n < NS; n++) begin
      wr(12'(32'h100 + n), 32'hABCD_EF00 | 32'(routeOf(n)));
      wr(12'(32'h200 + n), 32'h1234_5600 | 32'(vecOf(n)));
    end
    for (int n = 0; n < NS; n++) begin
      rd(12'(32'h100 + n), d); chk("R3 route byte", d, {24'h0, routeOf(n)});
      rd(12'(32'h200 + n), d); chk("R3 vector byte", d, {24'h0, vecOf(n)});
    end

    // R5 R9: per-line level-high sweep over every line
    enSh[0] = '1; enSh[1] = '1;
    wr(12'h40, 32'hFFFF_FFFF); wr(12'h44, 32'hFFFF_FFFF);
    for (int n = 0; n < NS; n++) begin
      irqIn[n] = 1'b1;
      setCfg(0, n, 1'b0);
      idle(6);
      expMsg("R9 sweep", n);
      accept();
      irqIn[n] = 1'b0;
      setCfg(0, n, 1'b1);
      idle(6);
      expNone("R5 sweep after drop");
    end

    // R8: message enable gates an unblocked pending line
    setCfg(1, 5, 1'b0);
    irqIn[5] = 1'b1;
    setCfg(0, 5, 1'b0);
    idle(6);
    expNone("R8 enable off");
    setCfg(1, 5, 1'b1);
    idle(3);
    expMsg("R8 enable on", 5);
    accept();
    irqIn[5] = 1'b0;
    setCfg(0, 5, 1'b1);
    idle(6);

    // R4 R12: active-low level on line 3
    setCfg(3, 3, 1'b1);
    setCfg(0, 3, 1'b0);
    idle(6);
    expMsg("R4 active-low", 3);
    accept(); idle(6);
    expNone("R12 still asserted");
    irqIn[3] = 1'b1; idle(6);
    expNone("R5 active-low inactive");
    irqIn[3] = 1'b0; idle(6);
    expMsg("R12 re-sent after inactive", 3);
    accept(); idle(4);
    setCfg(0, 3, 1'b1);
    setCfg(0, 3, 1'b0);
    idle(4);
    expMsg("R12 re-sent after block/unblock", 3);
    accept();
    setCfg(0, 3, 1'b1);
    setCfg(3, 3, 1'b0);
    idle(4);

    // R6 R11: rising edge on line 40
    setCfg(2, 40, 1'b1);
    clrLatch(40);
    setCfg(0, 40, 1'b0);
    idle(4);
    expNone("R6 edge no event");
    pulse(40);
    expMsg("R6 rising edge latched", 40);
    accept(); idle(4);
    expNone("R11 no repeat");
    pulse(40);
    expNone("R11 second edge before clear");
    clrLatch(40); idle(4);
    expNone("R11 after clear");
    pulse(40);
    expMsg("R11 new edge after clear", 40);
    accept();
    clrLatch(40);
    setCfg(0, 40, 1'b1);

    // R4: falling edge on line 41
    setCfg(2, 41, 1'b1);
    setCfg(3, 41, 1'b1);
    irqIn[41] = 1'b1; idle(6);
    clrLatch(41);
    setCfg(0, 41, 1'b0);
    idle(6);
    expNone("R4 rise ignored for falling");
    irqIn[41] = 1'b0; idle(6);
    expMsg("R4 falling edge", 41);
    accept();
    clrLatch(41);
    setCfg(0, 41, 1'b1);

    // R7: clear word zero vs one, observed through the enable
    setCfg(2, 42, 1'b1);
    clrLatch(42);
    setCfg(1, 42, 1'b0);
    setCfg(0, 42, 1'b0);
    pulse(42);
    expNone("R7 latched while disabled");
    wr(12'h84, 32'h0);
    setCfg(1, 42, 1'b1);
    idle(3);
    expMsg("R7 zero write kept latch", 42);
    accept();
    setCfg(1, 42, 1'b0);
    clrLatch(42);
    pulse(42);
    clrLatch(42);
    setCfg(1, 42, 1'b1);
    idle(4);
    expNone("R7 one write cleared latch");
    setCfg(0, 42, 1'b1);

    // R9 R10: simultaneous lines 2, 33, 60
    setCfg(0, 2, 1'b0); setCfg(0, 33, 1'b0); setCfg(0, 60, 1'b0);
    irqIn = (64'h1 << 2) | (64'h1 << 33) | (64'h1 << 60);
    idle(6);
    expMsg("R9 lowest first", 2);
    idle(5);
    expMsg("R10 held while not ready", 2);
    accept();
    expMsg("R9 second", 33);
    accept();
    expMsg("R9 third", 60);
    accept();
    expNone("R9 all delivered");
    irqIn = '0;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule